// File: doc/BRIEF.md
# Trap Return State Restorer

This block returns a processor from a trap handler. When a return strobe arrives while the trap level is above zero, it reads the saved record for the current level. That record holds a saved program counter, a saved next program counter and a packed saved-state word. From it, the block restores in one step:

- the program counter and next program counter;
- the condition-code byte and the address-space identifier;
- the processor-state field;
- the register-window pointer.

It then lowers the trap level by one. Two flavours exist:

- **Complete** resumes after the trapped instruction.
- **Retry** re-executes the trapped instruction.

The window pointer is saved in the packed word in counting order, but the block keeps it internally in reversed form. The saved value is first folded into the implemented window count, and the block stores the window count minus one minus the folded value.

When the processor-state bits that select the global register bank change across the restore, the block issues a one-cycle bank-swap request. The request carries the old and new bank-select codes. The register banks themselves live outside this block.

A trap-entry strobe raises the trap level. Per-level record storage is supplied by the surrounding logic as flat tables indexed by level.

Top module: `trs_restore`

## Requirements
- R1: A complete-type return (`ret_retry`=0) at trap level L>0 sets `pc` to the saved next-PC of table entry L-1 and `npc` to that value plus 4.
- R2: A retry-type return (`ret_retry`=1) sets `pc` to the saved PC of entry L-1 and `npc` to the saved next-PC of entry L-1.
- R3: `ccr` takes saved-state bits 39:32 (extended codes in its upper nibble, integer codes in its lower nibble), and `asi` takes saved-state bits 31:24.
- R4: `pstate` takes saved-state bits 19:8 ANDed with 12'hF3F, so bits 6 and 7 of the restored state are always 0.
- R5: When parameter GL_FEAT is 1, bit 0 of the restored state (the alternate-globals select) is forced to 0 before it is stored and compared; when GL_FEAT is 0 it is kept.
- R6: With F the saved-state bits 7:0 and N the parameter NWIN, `cwp` becomes N-1-(F mod N), and it is always below N.
- R7: `bank_swap` pulses together with `restored` exactly when the state bits {11,10,0} differ between the old and the new `pstate`. `bank_old` and `bank_new` then hold those bits packed as {b11,b10,b0}.
- R8: Every restored output and `tl`, which drops by one, change on the first clock edge after the strobe, in the same cycle as the one-cycle `restored` pulse. Without an accepted return they hold their values.
- R9: A return strobe at trap level 0 is ignored: no `restored` pulse and no change to any output.
- R10: `trap_take` raises `tl` by one, saturating at MAXTL. When `ret_valid` and `trap_take` are both high, the return is served and `trap_take` is ignored.
- R11: After reset, `pc`, `npc`, `ccr`, `asi`, `pstate`, `cwp`, `tl`, `bank_old` and `bank_new` are 0, and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_take | input | 1 | Trap entry: raise trap level |
| ret_valid | input | 1 | Trap-return strobe |
| ret_retry | input | 1 | 1 = retry, 0 = complete |
| tpc_tab | input | MAXTL x PC_W | Saved PC per level (entry L-1 for level L) |
| tnpc_tab | input | MAXTL x PC_W | Saved next-PC per level |
| tstate_tab | input | MAXTL x 40 | Packed saved-state word per level |
| pc | output | PC_W | Program counter |
| npc | output | PC_W | Next program counter |
| ccr | output | 8 | Condition-code byte |
| asi | output | 8 | Address-space identifier |
| pstate | output | 12 | Processor-state field |
| cwp | output | WIN_W | Internal (reversed) window pointer |
| tl | output | TL_W | Current trap level |
| restored | output | 1 | One-cycle pulse after an accepted return |
| bank_swap | output | 1 | Global-bank swap request |
| bank_old | output | 3 | Previous bank-select bits {b11,b10,b0} |
| bank_new | output | 3 | New bank-select bits {b11,b10,b0} |

## Verification
The bench builds two instances from the same stimulus. Both use NWIN=5, MAXTL=4 and PC_W=32; one has GL_FEAT=0 and the other GL_FEAT=1.

A window count that is not a power of two makes saved pointer values 4, 7 and 255 reach the fold-then-reverse path with distinct results. A depth of four lets the bench walk every table entry and hit the saturation limit.

The paired instances show the alternate-globals bit causing a bank swap in one variant while producing no swap in the other from identical saved words.

// File: rtl/trs_pkg.sv
package trs_pkg;

  localparam int unsigned TS_W       = 40;
  localparam int unsigned PS_W       = 12;
  localparam logic [11:0] PS_KEEP    = 12'hF3F;
  localparam int unsigned PS_AG_BIT  = 0;

  // Fold the saved pointer into range, then reverse it.
  function automatic logic [7:0] cwp_unsave(input logic [7:0] f, input int unsigned nwin);
    int unsigned v;
    v = int'(f);
    if (v >= nwin) v = v % nwin;
    return 8'(nwin - 1 - v);
  endfunction

  // Bank-select code from a state value: {b11,b10,b0}.
  function automatic logic [2:0] bank_code(input logic [11:0] ps);
    return {ps[11], ps[10], ps[0]};
  endfunction

endpackage

// File: rtl/trs_pc_sel.sv
module trs_pc_sel #(
  parameter int unsigned PC_W = 64
) (
  input  logic            is_retry,
  input  logic [PC_W-1:0] saved_pc,
  input  logic [PC_W-1:0] saved_npc,
  output logic [PC_W-1:0] pc_n,
  output logic [PC_W-1:0] npc_n
);
  always_comb begin
    if (is_retry) begin
      pc_n  = saved_pc;
      npc_n = saved_npc;
    end else begin
      pc_n  = saved_npc;
      npc_n = saved_npc + PC_W'(4);
    end
  end
endmodule

// File: rtl/trs_unpack.sv
module trs_unpack
  import trs_pkg::*;
#(
  parameter int unsigned NWIN    = 8,
  parameter int unsigned WIN_W   = 3,
  parameter bit          GL_FEAT = 1'b0
) (
  input  logic [TS_W-1:0]  word,
  output logic [7:0]       ccr_n,
  output logic [7:0]       asi_n,
  output logic [PS_W-1:0]  ps_n,
  output logic [WIN_W-1:0] cwp_n
);
  logic [PS_W-1:0] ps_masked;
  logic [7:0]      cwp_full;
  logic            unused_gap;

  assign ccr_n      = word[39:32];
  assign asi_n      = word[31:24];
  assign unused_gap = ^word[23:20];
  assign ps_masked  = word[19:8] & PS_KEEP;
  assign cwp_full   = cwp_unsave(word[7:0], NWIN);
  assign cwp_n      = WIN_W'(cwp_full);

  generate
    if (GL_FEAT) begin : g_gl
      always_comb begin
        ps_n = ps_masked;
        ps_n[PS_AG_BIT] = 1'b0;
      end
    end else begin : g_nogl
      assign ps_n = ps_masked;
    end
  endgenerate
endmodule

// File: rtl/trs_bank_cmp.sv
module trs_bank_cmp
  import trs_pkg::*;
(
  input  logic [PS_W-1:0] ps_old,
  input  logic [PS_W-1:0] ps_new,
  output logic            differ,
  output logic [2:0]      code_old,
  output logic [2:0]      code_new
);
  assign code_old = bank_code(ps_old);
  assign code_new = bank_code(ps_new);
  assign differ   = (code_old != code_new);
endmodule

// File: rtl/trs_restore.sv
module trs_restore
  import trs_pkg::*;
#(
  parameter int unsigned NWIN    = 8,
  parameter int unsigned MAXTL   = 5,
  parameter int unsigned PC_W    = 64,
  parameter bit          GL_FEAT = 1'b0,
  localparam int unsigned WIN_W  = $clog2(NWIN),
  localparam int unsigned TL_W   = $clog2(MAXTL + 1),
  localparam int unsigned IDX_W  = $clog2(MAXTL)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       trap_take,
  input  logic                       ret_valid,
  input  logic                       ret_retry,
  input  logic [MAXTL-1:0][PC_W-1:0] tpc_tab,
  input  logic [MAXTL-1:0][PC_W-1:0] tnpc_tab,
  input  logic [MAXTL-1:0][TS_W-1:0] tstate_tab,
  output logic [PC_W-1:0]            pc,
  output logic [PC_W-1:0]            npc,
  output logic [7:0]                 ccr,
  output logic [7:0]                 asi,
  output logic [PS_W-1:0]            pstate,
  output logic [WIN_W-1:0]           cwp,
  output logic [TL_W-1:0]            tl,
  output logic                       restored,
  output logic                       bank_swap,
  output logic [2:0]                 bank_old,
  output logic [2:0]                 bank_new
);
  // Named events, also observed by the bound checker.
  logic             ret_fire;
  logic             take_fire;
  logic [IDX_W-1:0] lvl_idx;

  assign ret_fire  = ret_valid && (tl != '0);
  assign take_fire = trap_take && !ret_valid && (tl != TL_W'(MAXTL));
  assign lvl_idx   = IDX_W'(tl - TL_W'(1));

  logic [PC_W-1:0]  pc_n, npc_n;
  logic [7:0]       ccr_n, asi_n;
  logic [PS_W-1:0]  ps_n;
  logic [WIN_W-1:0] cwp_n;
  logic             swap_n;
  logic [2:0]       code_old_n, code_new_n;

  trs_pc_sel #(.PC_W(PC_W)) u_pc_sel (
    .is_retry (ret_retry),
    .saved_pc (tpc_tab[lvl_idx]),
    .saved_npc(tnpc_tab[lvl_idx]),
    .pc_n     (pc_n),
    .npc_n    (npc_n)
  );

  trs_unpack #(.NWIN(NWIN), .WIN_W(WIN_W), .GL_FEAT(GL_FEAT)) u_unpack (
    .word (tstate_tab[lvl_idx]),
    .ccr_n(ccr_n),
    .asi_n(asi_n),
    .ps_n (ps_n),
    .cwp_n(cwp_n)
  );

  trs_bank_cmp u_bank_cmp (
    .ps_old  (pstate),
    .ps_new  (ps_n),
    .differ  (swap_n),
    .code_old(code_old_n),
    .code_new(code_new_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc        <= '0;
      npc       <= '0;
      ccr       <= '0;
      asi       <= '0;
      pstate    <= '0;
      cwp       <= '0;
      tl        <= '0;
      restored  <= 1'b0;
      bank_swap <= 1'b0;
      bank_old  <= '0;
      bank_new  <= '0;
    end else begin
      restored  <= ret_fire;
      bank_swap <= ret_fire && swap_n;
      if (ret_fire) begin
        pc       <= pc_n;
        npc      <= npc_n;
        ccr      <= ccr_n;
        asi      <= asi_n;
        pstate   <= ps_n;
        cwp      <= cwp_n;
        tl       <= tl - TL_W'(1);
        bank_old <= code_old_n;
        bank_new <= code_new_n;
      end else if (take_fire) begin
        tl <= tl + TL_W'(1);
      end
    end
  end
endmodule

// File: rtl/trs_restore_chk.sv
module trs_restore_chk #(
  parameter int unsigned NWIN    = 8,
  parameter int unsigned MAXTL   = 5,
  parameter int unsigned PC_W    = 64,
  parameter bit          GL_FEAT = 1'b0,
  parameter int unsigned WIN_W   = 3,
  parameter int unsigned TL_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ret_valid,
  input logic             ret_fire,
  input logic [PC_W-1:0]  pc,
  input logic [11:0]      pstate,
  input logic [WIN_W-1:0] cwp,
  input logic [TL_W-1:0]  tl,
  input logic             restored,
  input logic             bank_swap
);
  assert_ignore_level0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && tl == '0) |=> !restored);

  assert_level_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |=> (tl == $past(tl) - TL_W'(1)) && restored);

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_fire |=> $stable(pc) && $stable(pstate) && !restored);

  assert_swap_with_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bank_swap |-> restored);

  assert_cwp_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cwp) < int'(NWIN));

  assert_state_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate[7:6] == 2'b00));

  assert_alt_globals_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (GL_FEAT && restored) |-> !pstate[0]);

  assert_level_ceiling_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tl) <= int'(MAXTL));
endmodule

bind trs_restore trs_restore_chk #(
  .NWIN(NWIN), .MAXTL(MAXTL), .PC_W(PC_W), .GL_FEAT(GL_FEAT),
  .WIN_W(WIN_W), .TL_W(TL_W)
) u_chk (.*);

// File: tb/test_trs_restore.sv
`timescale 1ns/1ps
module test_trs_restore;
  localparam int NW = 5;
  localparam int MT = 4;
  localparam int PW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_take = 1'b0, ret_valid = 1'b0, ret_retry = 1'b0;
  logic [MT-1:0][PW-1:0] tpc_tab, tnpc_tab;
  logic [MT-1:0][39:0]   tstate_tab;

  logic [PW-1:0] pc_a, npc_a, pc_b, npc_b;
  logic [7:0]    ccr_a, asi_a, ccr_b, asi_b;
  logic [11:0]   ps_a, ps_b;
  logic [2:0]    cwp_a, cwp_b, tl_a, tl_b;
  logic          rs_a, rs_b, sw_a, sw_b;
  logic [2:0]    bo_a, bn_a, bo_b, bn_b;

  always #2 clk = ~clk;

  trs_restore #(.NWIN(NW), .MAXTL(MT), .PC_W(PW), .GL_FEAT(1'b0)) i_trs_restore (
    .clk(clk), .rst_n(rst_n), .trap_take(trap_take), .ret_valid(ret_valid),
    .ret_retry(ret_retry), .tpc_tab(tpc_tab), .tnpc_tab(tnpc_tab), .tstate_tab(tstate_tab),
    .pc(pc_a), .npc(npc_a), .ccr(ccr_a), .asi(asi_a), .pstate(ps_a), .cwp(cwp_a),
    .tl(tl_a), .restored(rs_a), .bank_swap(sw_a), .bank_old(bo_a), .bank_new(bn_a));

  trs_restore #(.NWIN(NW), .MAXTL(MT), .PC_W(PW), .GL_FEAT(1'b1)) i_trs_restore_gl (
    .clk(clk), .rst_n(rst_n), .trap_take(trap_take), .ret_valid(ret_valid),
    .ret_retry(ret_retry), .tpc_tab(tpc_tab), .tnpc_tab(tnpc_tab), .tstate_tab(tstate_tab),
    .pc(pc_b), .npc(npc_b), .ccr(ccr_b), .asi(asi_b), .pstate(ps_b), .cwp(cwp_b),
    .tl(tl_b), .restored(rs_b), .bank_swap(sw_b), .bank_old(bo_b), .bank_new(bn_b));

  typedef struct {
    logic [PW-1:0] pc, npc;
    logic [7:0]    ccr, asi;
    logic [11:0]   psa, psb;
    logic [2:0]    cwp, tl;
    logic          swa, swb;
    logic [2:0]    boa, bna, bob, bnb;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int m_tl = 0;
  logic [11:0] m_psa = '0, m_psb = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Independent model of the folded, reversed window pointer.
  function automatic logic [2:0] m_cwp(input logic [7:0] f);
    int r = int'(f);
    while (r >= NW) r = r - NW;
    return 3'(NW - 1 - r);
  endfunction

  function automatic logic [2:0] m_sel(input logic [11:0] p);
    return {p[11], p[10], p[0]};
  endfunction

  task automatic do_ret(input bit retry, input bit take_too);
    exp_t e;
    int k;
    logic [11:0] raw;
    k = m_tl - 1;
    raw = tstate_tab[k][19:8];
    e.pc  = retry ? tpc_tab[k] : tnpc_tab[k];
    e.npc = retry ? tnpc_tab[k] : tnpc_tab[k] + 32'd4;
    e.ccr = tstate_tab[k][39:32];
    e.asi = tstate_tab[k][31:24];
    e.psa = {raw[11:8], 2'b00, raw[5:0]};
    e.psb = {raw[11:8], 2'b00, raw[5:1], 1'b0};
    e.cwp = m_cwp(tstate_tab[k][7:0]);
    e.tl  = 3'(m_tl - 1);
    e.swa = m_sel(m_psa) != m_sel(e.psa);
    e.swb = m_sel(m_psb) != m_sel(e.psb);
    e.boa = m_sel(m_psa); e.bna = m_sel(e.psa);
    e.bob = m_sel(m_psb); e.bnb = m_sel(e.psb);
    m_psa = e.psa; m_psb = e.psb; m_tl = m_tl - 1;
    exp_q.push_back(e);
    ret_retry = retry; ret_valid = 1'b1; trap_take = take_too;
    @(negedge clk);
    ret_valid = 1'b0; trap_take = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_take();
    trap_take = 1'b1;
    @(negedge clk);
    trap_take = 1'b0;
    if (m_tl < MT) m_tl++;
    chk(tl_a == 3'(m_tl), "R10 level raise", 64'(tl_a), 64'(m_tl));
  endtask

  // Monitor: pop an expected item for every restore pulse.
  always @(negedge clk) begin
    if (rst_n && rs_a) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected restore", 64'(1), 64'(0));
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(pc_a == e.pc,   "R1/R2 pc",  64'(pc_a),  64'(e.pc));
        chk(npc_a == e.npc, "R1/R2 npc", 64'(npc_a), 64'(e.npc));
        chk(ccr_a == e.ccr && asi_a == e.asi, "R3 ccr/asi",
            64'({ccr_a, asi_a}), 64'({e.ccr, e.asi}));
        chk(ps_a == e.psa,  "R4 state",  64'(ps_a),  64'(e.psa));
        chk(ps_b == e.psb,  "R5 state gl", 64'(ps_b), 64'(e.psb));
        chk(cwp_a == e.cwp && cwp_b == e.cwp, "R6 cwp", 64'(cwp_a), 64'(e.cwp));
        chk(tl_a == e.tl && rs_b, "R8 level/pulse", 64'(tl_a), 64'(e.tl));
        chk(sw_a == e.swa && sw_b == e.swb, "R7 swap",
            64'({sw_a, sw_b}), 64'({e.swa, e.swb}));
        chk({bo_a, bn_a, bo_b, bn_b} == {e.boa, e.bna, e.bob, e.bnb}, "R7 codes",
            64'({bo_a, bn_a, bo_b, bn_b}), 64'({e.boa, e.bna, e.bob, e.bnb}));
        chk(pc_b == e.pc, "R1/R2 pc gl", 64'(pc_b), 64'(e.pc));
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // saved word: {ccr, asi, 4'h0, state12, cwp8}
    tpc_tab[0] = 32'h0000_1000; tnpc_tab[0] = 32'h0000_1004;
    tstate_tab[0] = {8'h01, 8'h22, 4'h0, 12'hFFE, 8'd4};
    tpc_tab[1] = 32'h0000_2000; tnpc_tab[1] = 32'h0000_2008;
    tstate_tab[1] = {8'hFF, 8'h00, 4'h0, 12'h435, 8'd0};
    tpc_tab[2] = 32'h0000_3000; tnpc_tab[2] = 32'h0000_3010;
    tstate_tab[2] = {8'h3C, 8'h14, 4'h0, 12'h401, 8'd3};
    tpc_tab[3] = 32'hFFFF_FFF8; tnpc_tab[3] = 32'hFFFF_FFFC;
    tstate_tab[3] = {8'hA5, 8'h80, 4'h0, 12'h0C1, 8'd7};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(pc_a == 0 && npc_a == 0 && tl_a == 0 && cwp_a == 0, "R11 reset regs",
        64'({pc_a, tl_a, cwp_a}), 64'(0));
    chk(ps_a == 0 && ccr_a == 0 && asi_a == 0 && !rs_a && !sw_a, "R11 reset state",
        64'({ps_a, ccr_a, asi_a}), 64'(0));

    // R9: return at level 0 ignored
    ret_valid = 1'b1;
    @(negedge clk);
    ret_valid = 1'b0;
    chk(!rs_a && !rs_b, "R9 no pulse", 64'(rs_a), 64'(0));
    chk(pc_a == 0 && tl_a == 0 && ps_a == 0 && cwp_a == 0, "R9 no change",
        64'({pc_a, tl_a}), 64'(0));

    // R10: raise to ceiling and saturate
    repeat (MT + 1) do_take();
    chk(tl_a == 3'(MT), "R10 saturate", 64'(tl_a), 64'(MT));

    do_ret(1'b0, 1'b0);  // entry 3 complete, cwp 7 folds
    do_ret(1'b1, 1'b0);  // entry 2 retry
    do_ret(1'b0, 1'b0);  // entry 1 complete, no swap
    do_ret(1'b1, 1'b0);  // entry 0 retry
    chk(tl_a == 0, "R8 level at bottom", 64'(tl_a), 64'(0));

    do_take();
    tstate_tab[0] = {8'h5A, 8'hC3, 4'h0, 12'hF3E, 8'hFF};
    do_ret(1'b0, 1'b1);  // R10: return wins over simultaneous trap entry
    chk(tl_a == 0, "R10 priority", 64'(tl_a), 64'(0));

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all restores seen", 64'(exp_q.size()), 64'(0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule